// File: doc/BRIEF.md
# Word-serial modular adder/subtractor over 2N

This unit adds or subtracts two multi-word operands modulo an even modulus M = 2N. Operands are assumed to already lie in [0, M). Keeping all values in this widened range means no final reduction to [0, N) is needed. This matches the range a Montgomery multiplier accepts and returns. One datapath serves both operations, and a select bit sampled with the start strobe picks which one runs.

The arithmetic runs one 32-bit word per cycle, least significant word first. A single 32-bit adder and a one-bit carry/borrow register do the work.

- The first pass forms the raw sum or difference.
- The second pass forms a corrected candidate: the sum minus M, or the difference plus M.
- At the end, the unit keeps whichever of the two lies in range.

The unit then waits through idle cycles, so every operation reports its result after the same fixed number of cycles. This lets a scheduler interleave it with a much longer multiplication without any handshake.

Top module: `mod2n_addsub`

## Requirements
- R1: With `op_sub` = 0, the result is (A + B) mod M. This includes sums that reach or exceed M, and sums that overflow the full operand width.
- R2: With `op_sub` = 1, the result is (A - B) mod M. When A < B the result is A - B + M; when A = B the result is 0.
- R3: A start accepted at clock edge k makes `done` high for exactly one cycle, after edge k + 41. The result appears on `res_out` in the same cycle as `done`.
- R4: A start pulse that arrives while `busy` is high is ignored. The running operation keeps its timing and its operands, and no extra `done` follows.
- R5: Whenever `done` is high, `res_out` is below the latched modulus.
- R6: `res_out` only changes on the edge that raises `done`; it holds its value otherwise.
- R7: After reset, `done` and `busy` are 0 and `res_out` is 0.
- R8: `busy` is high from the edge that accepts a start until the edge that raises `done`. A new start is accepted in the cycle where `done` is high.
- R9: Operands, modulus and operation select are captured at the accepting edge. Changes to these inputs while `busy` is high do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when the unit is idle |
| op_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| a_in | input | 256 | First operand, in [0, M) |
| b_in | input | 256 | Second operand, in [0, M) |
| mod2n | input | 256 | Even modulus M = 2N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| res_out | output | 256 | Result, held until the next operation completes |

## Verification
The hardest case to reach from the ports is the addition whose raw sum overflows all 256 bits. There, the corrected candidate must be chosen because of the carry out of the first pass, even though the second pass ends with a borrow. Random moduli almost never get close enough to the top of the range, so the stimulus fixes M at the largest even 256-bit value and adds operands just below it. Subtraction wrap-around, the A + B = M boundary and operand changes during a busy window are driven as directed cases around a seeded random mix of moduli of varied sizes.

// File: rtl/mod2n_pkg.sv
package mod2n_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  co;
    word_t r;
  } wres_t;

  // add: co is carry out; sub: co is borrow out
  function automatic wres_t word_op(input word_t x, input word_t y,
                                    input logic cin, input logic sub);
    logic [WORD_W:0] t;
    wres_t o;
    if (sub) begin
      t = {1'b0, x} + {1'b0, ~y} + {{WORD_W{1'b0}}, ~cin};
      o.co = ~t[WORD_W];
    end else begin
      t = {1'b0, x} + {1'b0, y} + {{WORD_W{1'b0}}, cin};
      o.co = t[WORD_W];
    end
    o.r = t[WORD_W-1:0];
    return o;
  endfunction
endpackage

// File: rtl/mod2n_word_alu.sv
module mod2n_word_alu
  import mod2n_pkg::*;
(
  input  word_t x,
  input  word_t y,
  input  logic  cin,
  input  logic  sub,
  output word_t r,
  output logic  cout
);
  wres_t res;
  always_comb begin
    res  = word_op(x, y, cin, sub);
    r    = res.r;
    cout = res.co;
  end
endmodule

// File: rtl/mod2n_seq.sv
module mod2n_seq #(
  parameter int NWORDS  = 8,
  parameter int LATENCY = 41,
  localparam int CW     = $clog2(LATENCY + 1),
  localparam int IDXW   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            accept,
  output logic            busy,
  output logic            pass1,
  output logic            pass2,
  output logic            last_word,
  output logic            fin,
  output logic [IDXW-1:0] widx
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (cnt == '0)              cnt <= start ? CW'(1) : '0;
    else if (cnt == CW'(LATENCY))    cnt <= '0;
    else                             cnt <= cnt + CW'(1);
  end

  always_comb begin
    busy      = (cnt != '0);
    accept    = start && !busy;
    pass1     = busy && (cnt <= CW'(NWORDS));
    pass2     = (cnt > CW'(NWORDS)) && (cnt <= CW'(2 * NWORDS));
    last_word = (widx == IDXW'(NWORDS - 1));
    fin       = (cnt == CW'(LATENCY));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept)  widx <= '0;
    else if (pass1 || pass2)
      widx <= last_word ? '0 : widx + IDXW'(1);
  end
endmodule

// File: rtl/mod2n_addsub.sv
module mod2n_addsub
  import mod2n_pkg::*;
#(
  parameter int NWORDS  = 8,
  parameter int LATENCY = 41,
  localparam int W      = WORD_W * NWORDS,
  localparam int IDXW   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_sub,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] mod2n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_out
);
  initial begin
    if (LATENCY < 2 * NWORDS + 1) $error("LATENCY too small for two passes");
  end

  logic [W-1:0] a_q, b_q, m_q, s_q, t_q;
  logic         op_q, cy_q, c1_q;

  logic            accept, pass1, pass2, last_word, fin;
  logic [IDXW-1:0] widx;

  mod2n_seq #(.NWORDS(NWORDS), .LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .pass1(pass1), .pass2(pass2), .last_word(last_word), .fin(fin), .widx(widx)
  );

  // word selection: pass 1 works on A/B, pass 2 on raw result and M
  word_t a_w, b_w, s_w, m_w, alu_x, alu_y, alu_r;
  logic  alu_sub, alu_co;
  always_comb begin
    a_w     = a_q[widx*WORD_W +: WORD_W];
    b_w     = b_q[widx*WORD_W +: WORD_W];
    s_w     = s_q[widx*WORD_W +: WORD_W];
    m_w     = m_q[widx*WORD_W +: WORD_W];
    alu_x   = pass1 ? a_w : s_w;
    alu_y   = pass1 ? b_w : m_w;
    alu_sub = pass1 ? op_q : ~op_q;
  end

  mod2n_word_alu u_alu (
    .x(alu_x), .y(alu_y), .cin(cy_q), .sub(alu_sub), .r(alu_r), .cout(alu_co)
  );

  // add: corrected if raw sum overflowed or (sum - M) did not borrow
  // sub: corrected if the raw difference borrowed
  logic pick_corr;
  always_comb pick_corr = op_q ? c1_q : (c1_q | ~cy_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; m_q <= '0; s_q <= '0; t_q <= '0;
      op_q <= 1'b0; cy_q <= 1'b0; c1_q <= 1'b0;
    end else if (accept) begin
      a_q <= a_in; b_q <= b_in; m_q <= mod2n; op_q <= op_sub;
      cy_q <= 1'b0;
    end else if (pass1) begin
      s_q[widx*WORD_W +: WORD_W] <= alu_r;
      cy_q <= last_word ? 1'b0 : alu_co;
      if (last_word) c1_q <= alu_co;
    end else if (pass2) begin
      t_q[widx*WORD_W +: WORD_W] <= alu_r;
      cy_q <= alu_co;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      res_out <= '0;
    end else begin
      done <= fin;
      if (fin) res_out <= pick_corr ? t_q : s_q;
    end
  end
endmodule

// File: rtl/mod2n_addsub_chk.sv
module mod2n_addsub_chk #(
  parameter int W   = 256,
  parameter int LAT = 41,
  localparam int CW = $clog2(LAT + 1)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_out,
  input logic [W-1:0] mod_q
);
  logic [CW-1:0] ck;
  always_ff @(posedge clk) begin
    if (!rst_n)                ck <= '0;
    else if (start && !busy)   ck <= CW'(1);
    else if (ck == CW'(LAT))   ck <= '0;
    else if (ck != '0)         ck <= ck + CW'(1);
  end

  a_r3_done_at_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (ck == CW'(LAT)) |=> done);
  a_r3_done_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ck) == CW'(LAT)));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r4_busy_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (ck != '0 && ck < CW'(LAT)) |=> busy);
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_out < mod_q));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_out));
endmodule

bind mod2n_addsub mod2n_addsub_chk #(.W(W), .LAT(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_out(res_out), .mod_q(m_q)
);

// File: tb/tb_mod2n_addsub.sv
module tb_mod2n_addsub;
  localparam int W = 256;
  localparam int LAT = 41;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_sub = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, mod2n = '0;
  logic busy, done;
  logic [W-1:0] res_out;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  mod2n_addsub dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .a_in(a_in),
    .b_in(b_in), .mod2n(mod2n), .busy(busy), .done(done), .res_out(res_out)
  );

  function automatic logic [W-1:0] expect_val(input bit sub, input logic [W-1:0] a,
                                              input logic [W-1:0] b, input logic [W-1:0] m);
    logic [W:0] t;
    if (!sub) begin
      t = {1'b0, a} + {1'b0, b};
      if (t >= {1'b0, m}) t = t - {1'b0, m};
    end else if (a >= b) t = {1'b0, a} - {1'b0, b};
    else t = {1'b0, a} + {1'b0, m} - {1'b0, b};
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // start at an edge, wait for done; returns cycles from accepting edge
  task automatic run_op(input bit sub, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] m, output logic [W-1:0] r, output int lat);
    op_sub = sub; a_in = a; b_in = b; mod2n = m; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(posedge clk); #1; lat++; end
    r = res_out;
  endtask

  task automatic op_check(input string req, input bit sub, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [W-1:0] m);
    logic [W-1:0] r;
    int lat;
    run_op(sub, a, b, m, r, lat);
    check(req, r, expect_val(sub, a, b, m));
    check("R3 latency", W'(lat), W'(LAT));
    @(posedge clk); #1;
    check("R3 single pulse", W'(done), '0);
    check("R6 hold", res_out, r);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] m, a, b, r, mtop;
    int lat;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R7 done", W'(done), '0);
    check("R7 busy", W'(busy), '0);
    check("R7 res", res_out, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    mtop = {{(W-1){1'b1}}, 1'b0};
    m = {8'h00, rnd256() >> 8} & ~W'(1);
    // directed corners
    op_check("R1 zero plus zero", 1'b0, '0, '0, m);
    op_check("R1 sum equals M", 1'b0, m >> 1, m - (m >> 1), m);
    op_check("R1 max plus max", 1'b0, m - 1, m - 1, m);
    op_check("R1 full-width overflow", 1'b0, mtop - 1, mtop - 1, mtop);
    op_check("R1 overflow near edge", 1'b0, mtop - 1, W'(1), mtop);
    op_check("R2 A equals B", 1'b1, m - 5, m - 5, m);
    op_check("R2 zero minus max", 1'b1, '0, m - 1, m);
    op_check("R2 top modulus wrap", 1'b1, W'(3), mtop - 1, mtop);
    op_check("R2 no wrap", 1'b1, m - 1, W'(1), m);

    // R8: busy immediately after accept
    op_sub = 1'b0; a_in = W'(7); b_in = W'(9); mod2n = W'(100); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    check("R8 busy after start", W'(busy), W'(1));
    // R4/R9: restart attempt and input changes while busy
    repeat (10) @(posedge clk); #1;
    start = 1'b1; a_in = W'(50); b_in = W'(60); op_sub = 1'b1; mod2n = W'(200);
    @(posedge clk); #1; start = 1'b0;
    lat = 11;
    while (!done && lat < 100) begin @(posedge clk); #1; lat++; end
    check("R4 timing kept", W'(lat), W'(LAT));
    check("R9 operands latched", res_out, W'(16));
    check("R8 busy low at done", W'(busy), '0);
    r = res_out;
    lat = 0;
    repeat (45) begin @(posedge clk); #1; if (done) lat++; end
    check("R4 no extra done", W'(lat), '0);
    check("R6 hold idle", res_out, r);

    // random mix
    for (int i = 0; i < 120; i++) begin
      int sh;
      sh = $urandom_range(0, 200);
      m = (rnd256() | {1'b1, {(W-1){1'b0}}}) >> sh;
      m = m & ~W'(1);
      if (m < W'(2)) m = W'(2);
      a = rnd256() % m;
      b = rnd256() % m;
      if (i % 2 == 0) op_check("R1 random add", 1'b0, a, b, m);
      else            op_check("R2 random sub", 1'b1, a, b, m);
    end

    // R8: back-to-back start in the done cycle
    run_op(1'b0, W'(3), W'(4), W'(20), r, lat);
    op_sub = 1'b1; a_in = W'(2); b_in = W'(5); mod2n = W'(20); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    check("R8 accept in done cycle", W'(busy), W'(1));
    lat = 1;
    while (!done && lat < 100) begin @(posedge clk); #1; lat++; end
    check("R2 back-to-back result", res_out, W'(17));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule